// File: doc/BRIEF.md
# Serial Audio Clock and Sample Interrupt Generator

This block times a stereo serial audio link. As clock master it divides the system clock down to a bit clock and a word strobe. It shifts the left and right sample words out MSB first, with the left word sent while the strobe is low. As a slave it produces no clocks. Instead it follows an external word strobe through a synchronizer and uses that strobe's edges for its timing.

On strobe edges chosen by a mode register, the block raises a one-cycle sample interrupt. The host programs the block through a single-cycle register write port: an 8-bit clock divider, a mode register, and left and right transmit words. A two-bit status output shows the current strobe level and which channel is active. Writing the divider restarts all master timing, so the next interrupt period is measured from that write.

Top module: `aud_serclk`

## Requirements
- R1: The divider resets to 8, and the mode register resets to 0 (slave, no interrupt sources). A write with `reg_sel`=0 loads the divider from `reg_wdata[7:0]` and restarts master timing. After the restart, bit clock and strobe are low and the left word is loaded. After a write that switches the block into master mode, the first strobe edge comes 64×(divider+1) cycles later.
- R2: In master mode (mode bit 0 = 1), `sclk_o` toggles every divider+1 system clocks, starting high divider+1 cycles after a restart.
- R3: In master mode the internal word strobe toggles on the 32nd falling edge of `sclk_o` in each word, and only on a falling edge. It is therefore one word per 64×(divider+1) cycles.
- R4: With mode bit 5 set, `irq_o` pulses on every strobe edge. In master mode the interval between pulses is 64×(divider+1) cycles, and the first pulse comes 64×(divider+1) cycles after a divider write.
- R5: Mode bit 3 selects strobe rising edges and mode bit 4 selects falling edges. With bits 3, 4 and 5 all clear, `irq_o` stays low. `irq_o` rises in the same cycle as the strobe level shown in `status_o[0]` changes.
- R6: In slave mode (mode bit 0 = 0), a change of `ext_ws_i` produces the selected interrupt 3 clock edges later: two synchronizer stages, then edge detection.
- R7: In slave mode `sclk_o` and `ws_o` stay low.
- R8: In master mode `ext_ws_i` has no effect on `irq_o`.
- R9: Mode bit 2 gates the strobe onto `ws_o`. When it is clear, `ws_o` stays low while interrupts still occur.
- R10: `sdata_o` carries the left word (`reg_sel`=2) MSB first while the strobe is low, then the right word (`reg_sel`=3) while it is high. Each bit is valid while `sclk_o` is high and changes as `sclk_o` falls.
- R11: `status_o[0]` is the current strobe level, and `status_o[1]` is 1 while the left channel is active (strobe low).
- R12: `irq_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_sel | input | 2 | Register select: 0 divider, 1 mode, 2 left word, 3 right word |
| reg_wdata | input | 32 | Write data |
| ext_ws_i | input | 1 | External word strobe used in slave mode |
| sclk_o | output | 1 | Bit clock (master mode) |
| ws_o | output | 1 | Word strobe (master mode, when enabled) |
| sdata_o | output | 1 | Serial transmit data |
| irq_o | output | 1 | Sample interrupt pulse |
| status_o | output | 2 | Bit 0 strobe level, bit 1 left channel active |

## Verification
The single-pulse and edge-coincidence properties assume that `ext_ws_i` holds each level for at least two clock cycles. Otherwise a rise and a fall could reach the detector on consecutive edges. The bench changes the external strobe only at negative clock edges and holds every level for at least five cycles. The strobe-on-falling-edge property is conditioned on the mode and divider having been stable for one cycle, because a restart or a switch into master mode may legally drop the strobe. The bench's register writes keep to that one-cycle write strobe.

// File: rtl/aud_serclk_pkg.sv
package aud_serclk_pkg;
    typedef enum logic [1:0] {
        SEL_DIV   = 2'd0,
        SEL_MODE  = 2'd1,
        SEL_LEFT  = 2'd2,
        SEL_RIGHT = 2'd3
    } reg_sel_e;

    localparam int MODE_W   = 6;
    localparam int M_MASTER = 0;
    localparam int M_WSEN   = 2;
    localparam int M_RISE   = 3;
    localparam int M_FALL   = 4;
    localparam int M_WORD   = 5;
    localparam logic [MODE_W-1:0] MODE_MASK = 6'b111101;
endpackage

// File: rtl/aud_serclk_div.sv
module aud_serclk_div #(
    parameter int DIV_W     = 8,
    parameter int WORD_BITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             sclk_o,
    output logic             ws_o,
    output logic             shift_o,
    output logic             toggle_o
);
    localparam int BCNT_W = $clog2(WORD_BITS);
    localparam logic [BCNT_W-1:0] BCNT_LAST = BCNT_W'(WORD_BITS - 1);

    typedef struct packed {
        logic [DIV_W-1:0]  pre;
        logic              sclk;
        logic [BCNT_W-1:0] bcnt;
        logic              ws;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        shift_o  = 1'b0;
        toggle_o = 1'b0;
        if (!run_i || restart_i) begin
            st_d = '0;
        end else if (st_q.pre == div_i) begin
            st_d.pre  = '0;
            st_d.sclk = ~st_q.sclk;
            if (st_q.sclk) begin
                // falling edge of the bit clock: next bit or next word
                if (st_q.bcnt == BCNT_LAST) begin
                    st_d.bcnt = '0;
                    st_d.ws   = ~st_q.ws;
                    toggle_o  = 1'b1;
                end else begin
                    st_d.bcnt = st_q.bcnt + 1'b1;
                    shift_o   = 1'b1;
                end
            end
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sclk_o = st_q.sclk;
    assign ws_o   = st_q.ws;
endmodule

// File: rtl/aud_serclk_sync.sv
module aud_serclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              hist;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.chain[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.hist = st_q.chain[STAGES-1];
        rise_o    = st_q.chain[STAGES-1] & ~st_q.hist;
        fall_o    = ~st_q.chain[STAGES-1] & st_q.hist;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.hist;
endmodule

// File: rtl/aud_serclk_shift.sv
module aud_serclk_shift #(
    parameter int WORD_BITS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_left_i,
    input  logic                 load_right_i,
    input  logic                 shift_i,
    input  logic [WORD_BITS-1:0] left_i,
    input  logic [WORD_BITS-1:0] right_i,
    output logic                 msb_o
);
    logic [WORD_BITS-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_left_i)       sh_d = left_i;
        else if (load_right_i) sh_d = right_i;
        else if (shift_i)      sh_d = {sh_q[WORD_BITS-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign msb_o = sh_q[WORD_BITS-1];
endmodule

// File: rtl/aud_serclk.sv
module aud_serclk
    import aud_serclk_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int WORD_BITS   = 32,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_RESET   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [1:0]           reg_sel,
    input  logic [WORD_BITS-1:0] reg_wdata,
    input  logic                 ext_ws_i,
    output logic                 sclk_o,
    output logic                 ws_o,
    output logic                 sdata_o,
    output logic                 irq_o,
    output logic [1:0]           status_o
);
    typedef struct packed {
        logic [DIV_W-1:0]     div;
        logic [MODE_W-1:0]    mode;
        logic [WORD_BITS-1:0] left;
        logic [WORD_BITS-1:0] right;
        logic                 irq;
    } top_st_t;

    top_st_t st_d, st_q;

    logic div_wr, mode_wr, go_master, master, wsen;
    logic m_sclk, m_ws, m_shift, m_toggle;
    logic s_level, s_rise, s_fall;
    logic ev_rise, ev_fall, load_left, load_right, ws_cur;
    logic [2:0] evt_sel;

    assign master  = st_q.mode[M_MASTER];
    assign wsen    = st_q.mode[M_WSEN];
    assign evt_sel = {st_q.mode[M_WORD], st_q.mode[M_FALL], st_q.mode[M_RISE]};

    aud_serclk_div #(.DIV_W(DIV_W), .WORD_BITS(WORD_BITS)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (master),
        .restart_i(div_wr),
        .div_i    (st_q.div),
        .sclk_o   (m_sclk),
        .ws_o     (m_ws),
        .shift_o  (m_shift),
        .toggle_o (m_toggle)
    );

    aud_serclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(ext_ws_i),
        .level_o(s_level),
        .rise_o (s_rise),
        .fall_o (s_fall)
    );

    aud_serclk_shift #(.WORD_BITS(WORD_BITS)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_left_i (load_left),
        .load_right_i(load_right),
        .shift_i     (m_shift & master),
        .left_i      (st_q.left),
        .right_i     (st_q.right),
        .msb_o       (sdata_o)
    );

    always_comb begin
        st_d      = st_q;
        div_wr    = reg_we && (reg_sel == SEL_DIV);
        mode_wr   = reg_we && (reg_sel == SEL_MODE);
        go_master = mode_wr && reg_wdata[M_MASTER] && !master;

        // strobe edges from the active timing source
        ev_rise = master ? (m_toggle & ~m_ws) : s_rise;
        ev_fall = master ? (m_toggle &  m_ws) : s_fall;

        load_left  = ev_fall | div_wr | go_master;
        load_right = ev_rise & ~load_left;

        st_d.irq = (ev_rise & (st_q.mode[M_RISE] | st_q.mode[M_WORD]))
                 | (ev_fall & (st_q.mode[M_FALL] | st_q.mode[M_WORD]));

        if (div_wr)  st_d.div  = reg_wdata[DIV_W-1:0];
        if (mode_wr) st_d.mode = reg_wdata[MODE_W-1:0] & MODE_MASK;
        if (reg_we && reg_sel == SEL_LEFT)  st_d.left  = reg_wdata;
        if (reg_we && reg_sel == SEL_RIGHT) st_d.right = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.div <= DIV_W'(DIV_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    assign ws_cur   = master ? m_ws : s_level;
    assign sclk_o   = m_sclk;
    assign ws_o     = master & wsen & m_ws;
    assign irq_o    = st_q.irq;
    assign status_o = {~ws_cur, ws_cur};
endmodule

// File: rtl/aud_serclk_chk.sv
module aud_serclk_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sclk_o,
    input logic       ws_o,
    input logic       irq_o,
    input logic [1:0] status_o,
    input logic       master,
    input logic       wsen,
    input logic       div_wr,
    input logic [2:0] evt_sel
);
    // R12: interrupt is one cycle wide
    p_irq_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R7: slave mode drives no clocks
    p_slave_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !master |-> (!sclk_o && !ws_o));

    // R3: with stable setup, the strobe only moves as the bit clock falls
    p_ws_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (master && $past(master) && wsen && $past(wsen) && !$past(div_wr)
         && (ws_o != $past(ws_o))) |-> $fell(sclk_o));

    // R5: no selected source, no interrupt
    p_no_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(evt_sel) == 3'b000) |-> !irq_o);

    // R5: interrupt coincides with a strobe level change
    p_irq_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && $stable(master)) |-> (status_o[0] != $past(status_o[0])));
endmodule

bind aud_serclk aud_serclk_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_o  (sclk_o),
    .ws_o    (ws_o),
    .irq_o   (irq_o),
    .status_o(status_o),
    .master  (master),
    .wsen    (wsen),
    .div_wr  (div_wr),
    .evt_sel (evt_sel)
);

// File: tb/sim_aud_serclk.sv
module sim_aud_serclk;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic        ext_ws_i = 1'b0;
    logic        sclk_o, ws_o, sdata_o, irq_o;
    logic [1:0]  status_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10ns clk = ~clk;

    aud_serclk u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ext_ws_i(ext_ws_i), .sclk_o(sclk_o),
        .ws_o(ws_o), .sdata_o(sdata_o), .irq_o(irq_o), .status_o(status_o)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one-cycle write; returns at the negedge after the write edge
    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // edges counted from the write edge until irq seen; limit+1 if none
    task automatic wait_irq(input int limit, output int n);
        n = 0;
        while (n <= limit) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (irq_o) return;
        end
    endtask

    task automatic t_reset();
        check(sclk_o == 0 && ws_o == 0 && irq_o == 0, "R7 reset outputs", {sclk_o, ws_o, irq_o}, 0);
        check(status_o == 2'b10, "R11 reset status", status_o, 2);
    endtask

    task automatic t_default_div();
        int n;
        wr(2'd1, 32'h25);
        wait_irq(2000, n);
        check(n == 576, "R1 default divider first irq", n, 576);
    endtask

    task automatic t_everyword();
        int n, hi, lo;
        wr(2'd1, 32'h25);
        wr(2'd0, 32'd0);
        wait_irq(500, n);
        check(n == 64, "R4 first irq div0", n, 64);
        wait_irq(500, n);
        check(n == 64, "R4 irq interval div0", n, 64);
        wr(2'd0, 32'd3);
        hi = 0; lo = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (sclk_o) hi++; else lo++;
        end
        check(hi == 4 && lo == 4, "R2 sclk half period div3", hi, 4);
        wait_irq(500, n);
        check(n == 248, "R4 irq after div3 restart", n, 248);
    endtask

    task automatic t_rise();
        int n;
        wr(2'd1, 32'h0D);
        wr(2'd0, 32'd2);
        wait_irq(1000, n);
        check(n == 192, "R5 rising first irq", n, 192);
        check(ws_o == 1 && status_o == 2'b01, "R5 strobe high at rise irq", ws_o, 1);
        wait_irq(1000, n);
        check(n == 384, "R5 rising interval", n, 384);
    endtask

    task automatic t_fall();
        int n;
        wr(2'd1, 32'h15);
        wr(2'd0, 32'd2);
        wait_irq(1000, n);
        check(n == 384, "R5 falling first irq", n, 384);
        check(ws_o == 0 && status_o == 2'b10, "R11 strobe low at fall irq", status_o, 2);
    endtask

    task automatic t_noevt();
        int n, tg;
        logic prev;
        wr(2'd1, 32'h05);
        wr(2'd0, 32'd0);
        tg = 0; n = 0; prev = ws_o;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (irq_o) n++;
            if (ws_o != prev) tg++;
            prev = ws_o;
        end
        check(n == 0, "R5 no sources no irq", n, 0);
        check(tg == 3, "R3 strobe toggles in 200 cycles div0", tg, 3);
    endtask

    task automatic t_wsen();
        int n, hi;
        wr(2'd1, 32'h21);
        wr(2'd0, 32'd0);
        hi = 0;
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            if (ws_o) hi++;
            if (irq_o) n++;
        end
        check(hi == 0, "R9 strobe gated off", hi, 0);
        wait_irq(200, n);
        check(n <= 64, "R9 irq still produced", n, 64);
    endtask

    task automatic t_shift();
        logic [31:0] lw, rw, wsl, wsr;
        int k;
        wr(2'd1, 32'h25);
        wr(2'd2, 32'hA5C3_0F96);
        wr(2'd3, 32'h3C5A_F00F);
        wr(2'd0, 32'd0);
        k = 0; lw = '0; rw = '0; wsl = '0; wsr = '0;
        for (int j = 1; j <= 128; j++) begin
            @(negedge clk);
            if (j % 2 == 1) begin
                if (k < 32) begin lw = {lw[30:0], sdata_o}; wsl = {wsl[30:0], ws_o}; end
                else        begin rw = {rw[30:0], sdata_o}; wsr = {wsr[30:0], ws_o}; end
                k++;
            end
        end
        check(lw == 32'hA5C3_0F96, "R10 left word MSB first", lw, 32'hA5C3_0F96);
        check(rw == 32'h3C5A_F00F, "R10 right word MSB first", rw, 32'h3C5A_F00F);
        check(wsl == 32'h0 && wsr == 32'hFFFF_FFFF, "R10 strobe level per word", wsl, 0);
    endtask

    task automatic t_restart();
        int n;
        wr(2'd1, 32'h25);
        wr(2'd0, 32'd1);
        repeat (50) @(negedge clk);
        wr(2'd0, 32'd1);
        wait_irq(500, n);
        check(n == 128, "R1 divider write restarts timing", n, 128);
    endtask

    task automatic t_master_ignore();
        int n;
        wr(2'd1, 32'h39);
        wr(2'd0, 32'd255);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            ext_ws_i = ~ext_ws_i;
            repeat (5) begin
                @(negedge clk);
                if (irq_o) n++;
            end
        end
        ext_ws_i = 1'b0;
        check(n == 0, "R8 external strobe ignored in master", n, 0);
    endtask

    task automatic t_slave();
        int n;
        wr(2'd1, 32'h18);
        repeat (6) @(negedge clk);
        check(sclk_o == 0 && ws_o == 0, "R7 slave clocks idle", {sclk_o, ws_o}, 0);
        ext_ws_i = 1'b1;
        wait_irq(20, n);
        check(n == 3, "R6 slave rise latency", n, 3);
        check(status_o == 2'b01, "R11 slave status high", status_o, 1);
        repeat (5) @(negedge clk);
        ext_ws_i = 1'b0;
        wait_irq(20, n);
        check(n == 3, "R6 slave fall latency", n, 3);
        wr(2'd1, 32'h08);
        repeat (5) @(negedge clk);
        ext_ws_i = 1'b1;
        wait_irq(20, n);
        check(n == 3, "R5 slave rise selected", n, 3);
        repeat (5) @(negedge clk);
        ext_ws_i = 1'b0;
        wait_irq(20, n);
        check(n == 21, "R5 slave fall not selected", n, 21);
        check(sclk_o == 0 && ws_o == 0, "R7 slave clocks idle after edges", {sclk_o, ws_o}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default_div();
        t_everyword();
        t_rise();
        t_fall();
        t_noevt();
        t_wsen();
        t_shift();
        t_restart();
        t_master_ignore();
        t_slave();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule